// File: doc/BRIEF.md
# Error Feedback Noise Shaper

This block is a digital delta-sigma modulator in error-feedback form. It takes an unsigned input word on every cycle where the sample-valid input is high and returns a shorter signed word. To produce that word it forms an internal sum, keeps the upper bits and drops the lowest `RES_W` bits. The dropped bits are the negated quantization error. They are held in a short history and returned to the next samples through a binomial FIR, so the error reaching the output is shaped by exactly (1 - z^-1)^ORDER. The signal path is a pure unity gain.

The order can be 1, 2 or 3; order 3 is the main configuration and the lower orders serve as smaller stages. The step size 2^RES_W is set apart from the input width, so one modulator can reduce a wide word to a few bits ahead of a multibit converter or a divider control. The feedback filter is an FIR and the truncator is wide enough for the worst excursion, so the loop cannot overload and needs no clipping. An order outside 1..3 or a residue width outside 1..IN_W-1 stops elaboration.

Top module: `efm_shaper`

## Requirements
- R1: On each accepted sample the internal sum is v = x + sum over k of c_k * r[n-k], where r[n-k] is the residue of the k-th previous accepted sample. The coefficients are (1) for order 1, (2, -1) for order 2 and (3, -3, 1) for order 3.
- R2: The output is y = floor(v / 2^RES_W) in two's complement of width IN_W-RES_W+ORDER+1. The residue stored for the next sample is v - y*2^RES_W, an unsigned value in [0, 2^RES_W).
- R3: When `in_vld` is high at a rising edge, `y_o` takes the new quantized value and `out_vld` is high after that edge. Both are readable from that edge until the next one.
- R4: When `in_vld` is low at a rising edge, `y_o` and the residue history keep their values and `out_vld` is low after that edge.
- R5: Asserting `rst_n` low clears `y_o`, `out_vld` and every residue history entry at once, with no clock edge needed. The first accepted sample after reset therefore produces x >> RES_W.
- R6: Every output stays within 2^(ORDER-1)*(2^RES_W - 1) of its input when scaled by the step: |y*2^RES_W - x| <= 2^(ORDER-1)*(2^RES_W - 1). The quantizer never overloads.
- R7: Over any run of accepted samples since reset, the sum of (y*2^RES_W - x) stays within ±2^(ORDER-1)*(2^RES_W - 1). For a constant input, the long-run mean of y times the step therefore equals the input exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Sample valid; acts as the clock enable of the loop |
| x_i | input | IN_W | Unsigned input sample |
| out_vld | output | 1 | High for one cycle after each accepted sample |
| y_o | output | IN_W-RES_W+ORDER+1 | Signed quantized output |

## Verification
The bench drives three instances at once, one per order, and follows each with an integer recurrence model. A wrong coefficient sign, a residue tap that is out of order, or a quantizer that rounds toward zero instead of flooring would show up as a drifting output within a few samples. Gaps in the valid input are aimed at a history that shifts on idle cycles, which would corrupt the shaping without changing the output at once. Constant inputs at full scale, zero, mid-scale and an odd pattern test the scaled-error bound and the accumulated-error bound. A loop with a missing tap or a wrong truncation width breaks those bounds, so its mean no longer matches the input. A reset applied in the middle of a run and checked before the next edge catches history that is cleared only synchronously, or not cleared at all.

// File: rtl/efm_pkg.sv
package efm_pkg;
  // Feedback coefficient applied to the residue delayed by k samples,
  // chosen so that the quantization error sees (1 - z^-1)^order.
  function automatic int fb_coef(input int order, input int k);
    int c;
    c = 1;
    for (int i = 0; i < k; i++) c = c * (order - i) / (i + 1);
    return (k % 2 == 1) ? c : -c;
  endfunction
endpackage

// File: rtl/efm_hist.sv
module efm_hist #(
  parameter int RES_W = 6,
  parameter int DEPTH = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         en,
  input  logic [RES_W-1:0]             din,
  output logic [DEPTH-1:0][RES_W-1:0]  taps
);
  logic [DEPTH-1:0][RES_W-1:0] taps_q, taps_d;

  always_comb begin
    taps_d[0] = din;
    for (int k = 1; k < DEPTH; k++) taps_d[k] = taps_q[k-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  taps_q <= '0;
    else if (en) taps_q <= taps_d;
  end

  assign taps = taps_q;
endmodule

// File: rtl/efm_fb_sum.sv
module efm_fb_sum #(
  parameter int IN_W  = 16,
  parameter int RES_W = 6,
  parameter int ORDER = 3,
  parameter int SUM_W = 20
) (
  input  logic [IN_W-1:0]               x,
  input  logic [ORDER-1:0][RES_W-1:0]   taps,
  output logic signed [SUM_W-1:0]       v
);
  logic signed [SUM_W-1:0] term [ORDER];
  logic signed [SUM_W-1:0] acc;

  for (genvar k = 0; k < ORDER; k++) begin : g_tap
    localparam int COEF = efm_pkg::fb_coef(ORDER, k + 1);
    localparam logic signed [SUM_W-1:0] COEF_S = SUM_W'(COEF);
    assign term[k] = COEF_S * $signed({{(SUM_W-RES_W){1'b0}}, taps[k]});
  end

  always_comb begin
    acc = $signed({{(SUM_W-IN_W){1'b0}}, x});
    for (int k = 0; k < ORDER; k++) acc = acc + term[k];
  end

  assign v = acc;
endmodule

// File: rtl/efm_trunc.sv
module efm_trunc #(
  parameter int SUM_W = 20,
  parameter int RES_W = 6
) (
  input  logic signed [SUM_W-1:0]        v,
  output logic signed [SUM_W-RES_W-1:0]  q,
  output logic [RES_W-1:0]               res
);
  // Dropping the low bits of a two's complement word is a floor division.
  assign q   = v[SUM_W-1:RES_W];
  assign res = v[RES_W-1:0];
endmodule

// File: rtl/efm_shaper.sv
module efm_shaper #(
  parameter int IN_W  = 16,
  parameter int RES_W = 6,
  parameter int ORDER = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_vld,
  input  logic [IN_W-1:0]               x_i,
  output logic                          out_vld,
  output logic signed [IN_W-RES_W+ORDER:0] y_o
);
  localparam int OUT_W = IN_W - RES_W + ORDER + 1;
  localparam int SUM_W = OUT_W + RES_W;

  if (ORDER < 1 || ORDER > 3) begin : g_bad_order
    $error("efm_shaper: ORDER must be 1, 2 or 3");
  end
  if (RES_W < 1 || RES_W >= IN_W) begin : g_bad_res
    $error("efm_shaper: RES_W must lie in 1..IN_W-1");
  end

  logic [ORDER-1:0][RES_W-1:0] taps;
  logic signed [SUM_W-1:0]     v;
  logic signed [OUT_W-1:0]     q;
  logic [RES_W-1:0]            res;
  logic signed [OUT_W-1:0]     y_q, y_d;
  logic                        vld_q, vld_d;

  efm_hist #(.RES_W(RES_W), .DEPTH(ORDER)) u_hist (
    .clk(clk), .rst_n(rst_n), .en(in_vld), .din(res), .taps(taps)
  );

  efm_fb_sum #(.IN_W(IN_W), .RES_W(RES_W), .ORDER(ORDER), .SUM_W(SUM_W)) u_sum (
    .x(x_i), .taps(taps), .v(v)
  );

  efm_trunc #(.SUM_W(SUM_W), .RES_W(RES_W)) u_trunc (
    .v(v), .q(q), .res(res)
  );

  always_comb begin
    y_d   = q;
    vld_d = in_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_q   <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (in_vld) y_q <= y_d;
    end
  end

  assign y_o     = y_q;
  assign out_vld = vld_q;
endmodule

// File: rtl/efm_shaper_chk.sv
module efm_shaper_chk #(
  parameter int IN_W  = 16,
  parameter int RES_W = 6,
  parameter int ORDER = 3
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           in_vld,
  input logic [IN_W-1:0]                x_i,
  input logic                           out_vld,
  input logic signed [IN_W-RES_W+ORDER:0] y_o
);
  localparam int     OUT_W = IN_W - RES_W + ORDER + 1;
  localparam longint STEP  = longint'(1) << RES_W;
  localparam longint SPAN  = (longint'(1) << (ORDER - 1)) * (STEP - 1);
  localparam longint YMIN  = -(longint'(1) << (ORDER - 1));
  localparam longint YMAX  = (longint'(1) << (IN_W - RES_W)) - 1 + (longint'(1) << (ORDER - 1));

  logic   seen_q;
  longint y_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      seen_q <= 1'b0;
    else if (in_vld) seen_q <= 1'b1;
  end

  always_comb y_l = longint'(y_o);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);  // R3

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> ($stable(y_o) && !out_vld));  // R4

  AST_FIRST_IS_TRUNC: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !seen_q) |=> (y_o == OUT_W'($past(x_i) >> RES_W)));  // R5

  AST_NO_OVERLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (y_l >= YMIN && y_l <= YMAX));  // R6

  AST_ERR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> ((y_l * STEP - longint'($past(x_i))) <= SPAN &&
                (y_l * STEP - longint'($past(x_i))) >= -SPAN));  // R6
endmodule

bind efm_shaper efm_shaper_chk #(.IN_W(IN_W), .RES_W(RES_W), .ORDER(ORDER)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .x_i(x_i), .out_vld(out_vld), .y_o(y_o)
);

// File: tb/sim_efm_shaper.sv
`timescale 1ns/1ps
module sim_efm_shaper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0;
  logic [15:0] xs = '0;

  always #2.5 clk = ~clk;

  logic               ov0, ov1, ov2;
  logic signed [13:0] y0;
  logic signed [9:0]  y1;
  logic signed [9:0]  y2;

  efm_shaper #(.IN_W(16), .RES_W(6), .ORDER(3)) u0 (
    .clk(clk), .rst_n(rst_n), .in_vld(vld), .x_i(xs), .out_vld(ov0), .y_o(y0));
  efm_shaper #(.IN_W(12), .RES_W(4), .ORDER(1)) u1 (
    .clk(clk), .rst_n(rst_n), .in_vld(vld), .x_i(xs[11:0]), .out_vld(ov1), .y_o(y1));
  efm_shaper #(.IN_W(10), .RES_W(3), .ORDER(2)) u2 (
    .clk(clk), .rst_n(rst_n), .in_vld(vld), .x_i(xs[9:0]), .out_vld(ov2), .y_o(y2));

  int     n_chk = 0;
  int     n_err = 0;
  int     ORD [3] = '{3, 1, 2};
  int     LW  [3] = '{6, 4, 3};
  int     WW  [3] = '{16, 12, 10};
  longint hist [3][3];
  longint ey   [3];
  bit     ev   [3];
  longint acc  [3];

  function automatic longint coef(int o, int k);
    case (o)
      3: return (k == 0) ? 3 : (k == 1) ? -3 : (k == 2) ? 1 : 0;
      2: return (k == 0) ? 2 : (k == 1) ? -1 : 0;
      default: return (k == 0) ? 1 : 0;
    endcase
  endfunction

  function automatic longint span(int i);
    return (longint'(1) << (ORD[i] - 1)) * ((longint'(1) << LW[i]) - 1);
  endfunction

  function automatic longint act_y(int i);
    case (i)
      0: return longint'(y0);
      1: return longint'(y1);
      default: return longint'(y2);
    endcase
  endfunction

  function automatic bit act_v(int i);
    case (i)
      0: return ov0;
      1: return ov1;
      default: return ov2;
    endcase
  endfunction

  function automatic longint in_of(int i, logic [15:0] x);
    return longint'(x) & ((longint'(1) << WW[i]) - 1);
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 3; i++) begin
      for (int k = 0; k < 3; k++) hist[i][k] = 0;
      ey[i] = 0; ev[i] = 0; acc[i] = 0;
    end
  endtask

  task automatic model_step(bit v, logic [15:0] x);
    for (int i = 0; i < 3; i++) begin
      ev[i] = v;
      if (v) begin
        longint s, y, r;
        s = in_of(i, x);
        for (int k = 0; k < 3; k++) s = s + coef(ORD[i], k) * hist[i][k];
        y = s >>> LW[i];
        r = s - (y <<< LW[i]);
        hist[i][2] = hist[i][1];
        hist[i][1] = hist[i][0];
        hist[i][0] = r;
        ey[i] = y;
      end
    end
  endtask

  // One clock: drive at the falling edge, compare just after the rising edge.
  task automatic cyc(bit v, logic [15:0] x);
    @(negedge clk);
    vld = v;
    xs  = x;
    model_step(v, x);
    @(posedge clk);
    #1;
    for (int i = 0; i < 3; i++) begin
      longint ya, xi;
      ya = act_y(i);
      xi = in_of(i, x);
      if (v) begin
        check(act_v(i) == 1'b1, "R3", "out_vld after accepted sample", act_v(i), 1);
        check(ya == ey[i], "R1 R2", "quantized output", ya, ey[i]);
        check((ya * (longint'(1) << LW[i]) - xi) <= span(i) &&
              (ya * (longint'(1) << LW[i]) - xi) >= -span(i),
              "R6", "scaled error", ya * (longint'(1) << LW[i]) - xi, 0);
        acc[i] = acc[i] + ya * (longint'(1) << LW[i]) - xi;
      end else begin
        check(act_v(i) == 1'b0, "R4", "out_vld on idle cycle", act_v(i), 0);
        check(ya == ey[i], "R4", "output held on idle cycle", ya, ey[i]);
      end
    end
  endtask

  task automatic pulse_reset();
    @(negedge clk);
    vld = 1'b0;
    #1 rst_n = 1'b0;
    #0.5;
    for (int i = 0; i < 3; i++) begin
      check(act_y(i) == 0, "R5", "output cleared without an edge", act_y(i), 0);
      check(act_v(i) == 1'b0, "R5", "out_vld cleared without an edge", act_v(i), 0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] consts [4];
    void'($urandom(32'd7731));
    model_reset();
    repeat (3) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      check(act_y(i) == 0, "R5", "output in reset", act_y(i), 0);
      check(act_v(i) == 1'b0, "R5", "out_vld in reset", act_v(i), 0);
    end
    rst_n = 1'b1;

    // First accepted sample after reset is the plain truncation.
    cyc(1'b1, 16'hABCD);
    for (int i = 0; i < 3; i++)
      check(act_y(i) == (in_of(i, 16'hABCD) >> LW[i]), "R5", "first output is truncated input",
            act_y(i), in_of(i, 16'hABCD) >> LW[i]);
    cyc(1'b0, 16'h1234);
    cyc(1'b0, 16'hFFFF);
    cyc(1'b1, 16'h0040);

    // Random samples with gaps in the valid input.
    for (int n = 0; n < 3000; n++)
      cyc(($urandom % 4) != 0, 16'($urandom));

    // Constant inputs from reset: accumulated error stays bounded.
    consts = '{16'hFFFF, 16'h0000, 16'h8001, 16'h0155};
    for (int c = 0; c < 4; c++) begin
      pulse_reset();
      for (int n = 0; n < 1500; n++) cyc(1'b1, consts[c]);
      for (int i = 0; i < 3; i++)
        check(acc[i] <= span(i) && acc[i] >= -span(i), "R7", "accumulated scaled error",
              acc[i], 0);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule